// File: doc/BRIEF.md
# Merged Shared-Read Responder

This block is one slice of a private cache's coherence controller. It serves a forwarded read request that names a whole group of readers at once. The request carries a bit mask with one bit per node. The owning cache answers the whole group with a single multicast data beat and updates the line's MOESI-style state. Tag lookup, replacement and the processor load/store path live elsewhere: the line's current state, data and dirty flag, and the writeback buffer contents, arrive as inputs.

The block also covers the requester side of the same exchange. When the local cache takes a data response on its shared-read path, the block records the node that sent the data. When the local cache later sends its shared-unblock message to the directory, that message names the recorded node as the current owner of the line.

The forwarded-request port and the response port use a valid/ready handshake. The request is consumed only in the cycle in which its reply is taken. The state update is issued in that same cycle.

Top module: `merged_read_responder`

## Requirements
- R1: With line state code 3 (owned), a forwarded request is answered with a reply of type 1 (shared data). The reply's destination equals the request mask, its data and dirty flag come from the line, and no state write is issued.
- R2: With line state code 4 (dirty-exclusive) or code 5 (modified), the reply is shared data (type 1) from the line, sent to the mask. On the handshake cycle a state write to code 3 (owned) is issued.
- R3: With line state code 6 (owned, upgrade pending), the reply is shared data (type 1) from the line, sent to the mask, and no state write is issued.
- R4: With line state code 7 (evicting from owned) or code 8 (evicting from modified), the reply is plain data (type 0). Its data and dirty flag come from the writeback buffer. On the handshake cycle a state write to code 7 is issued.
- R5: With line state codes 9 to 13 (transient), and with any other code outside 3 to 8, the request is stalled. No reply is valid, the request-ready output stays low and no state write is issued.
- R6: Every reply carries an ack count equal to the parameter N, the number of private caches.
- R7: The request-ready output and the state write are high only in a cycle where a reply is valid and the response port is ready. While the response port is not ready, the reply stays valid with the same content.
- R8: One clock edge after a data response is accepted on the requester side, the unblock owner output shows that response's sender identity.
- R9: The recorded owner changes only when a data response is accepted. A shared-unblock request produces a valid unblock in the same cycle, carrying the recorded owner.
- R10: After reset, the recorded owner is node 0 and no unblock is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fwdValid | input | 1 | Forwarded merged read request present |
| fwdReady | output | 1 | Request consumed this cycle |
| fwdMask | input | N | One bit per requesting node |
| lineState | input | 4 | Current line state code |
| lineData | input | W | Current line data |
| lineDirty | input | 1 | Current line dirty flag |
| wbData | input | W | Writeback buffer data |
| wbDirty | input | 1 | Writeback buffer dirty flag |
| rspValid | output | 1 | Reply beat valid |
| rspReady | input | 1 | Response network accepts the beat |
| rspDest | output | N | Multicast destination mask |
| rspType | output | 1 | 1 = shared data, 0 = plain data |
| rspData | output | W | Reply data |
| rspDirty | output | 1 | Reply dirty flag |
| rspAcks | output | $clog2(N+1) | Ack count, equal to N |
| stateWe | output | 1 | Line state write strobe |
| stateNew | output | 4 | Line state code to write |
| dataInValid | input | 1 | Requester side: data response accepted |
| dataInSender | input | $clog2(N) | Sender of that data response |
| unblkReq | input | 1 | Requester side: send shared unblock now |
| unblkValid | output | 1 | Shared-unblock message valid |
| unblkOwner | output | $clog2(N) | Recorded current-owner identity |

## Verification
The bench goes after the states that must not reply. A design that served a transient or non-owning line would drive data the cache does not own and pop a request that should have waited. It checks that only the two eviction states take their data from the writeback buffer and send plain data; swapping either source or type would hand stale data to the readers. It holds the response port not ready, because a design that popped the request or wrote the state at that point would lose the reply or move the line early. It also checks that the unblock names the node that last sent data and keeps that identity while no new data arrives.

// File: rtl/mrr_pkg.sv
package mrr_pkg;

  typedef enum logic [3:0] {
    LS_INV  = 4'd0,
    LS_SHR  = 4'd1,
    LS_EXC  = 4'd2,
    LS_OWN  = 4'd3,
    LS_DEX  = 4'd4,
    LS_MOD  = 4'd5,
    LS_OUPG = 4'd6,
    LS_EVO  = 4'd7,
    LS_EVM  = 4'd8,
    LS_TI   = 4'd9,
    LS_TS   = 4'd10,
    LS_TO   = 4'd11,
    LS_TD   = 4'd12,
    LS_TM   = 4'd13
  } lineState_e;

  typedef enum logic {
    RK_PLAIN  = 1'b0,
    RK_SHARED = 1'b1
  } rspKind_e;

  typedef struct packed {
    logic       serve;
    rspKind_e   kind;
    logic       useWb;
    logic       writeState;
    lineState_e newState;
  } ctrlStrobe_t;

endpackage

// File: rtl/mrr_ctrl.sv
module mrr_ctrl
  import mrr_pkg::*;
(
  input  logic        fwdValid,
  input  logic [3:0]  lineState,
  input  logic        rspReady,
  output ctrlStrobe_t strobe,
  output logic        fwdReady,
  output logic        stateWe
);

  lineState_e curState;
  assign curState = lineState_e'(lineState);

  always_comb begin
    strobe = '{serve: 1'b0, kind: RK_SHARED, useWb: 1'b0,
               writeState: 1'b0, newState: curState};
    unique case (curState)
      LS_OWN, LS_OUPG: begin
        strobe.serve = 1'b1;
      end
      LS_DEX, LS_MOD: begin
        strobe.serve      = 1'b1;
        strobe.writeState = 1'b1;
        strobe.newState   = LS_OWN;
      end
      LS_EVO, LS_EVM: begin
        strobe.serve      = 1'b1;
        strobe.kind       = RK_PLAIN;
        strobe.useWb      = 1'b1;
        strobe.writeState = 1'b1;
        strobe.newState   = LS_EVO;
      end
      default: begin
        strobe.serve = 1'b0;
      end
    endcase
  end

  logic handshake;
  assign handshake = fwdValid && strobe.serve && rspReady;
  assign fwdReady  = handshake;
  assign stateWe   = handshake && strobe.writeState;

endmodule

// File: rtl/mrr_datapath.sv
module mrr_datapath
  import mrr_pkg::*;
#(
  parameter int N   = 4,
  parameter int W   = 32,
  localparam int IDW = $clog2(N),
  localparam int ACW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctrlStrobe_t    strobe,
  input  logic           fwdValid,
  input  logic [N-1:0]   fwdMask,
  input  logic [W-1:0]   lineData,
  input  logic           lineDirty,
  input  logic [W-1:0]   wbData,
  input  logic           wbDirty,
  output logic           rspValid,
  output logic [N-1:0]   rspDest,
  output logic           rspType,
  output logic [W-1:0]   rspData,
  output logic           rspDirty,
  output logic [ACW-1:0] rspAcks,
  output logic [3:0]     stateNew,
  input  logic           dataInValid,
  input  logic [IDW-1:0] dataInSender,
  input  logic           unblkReq,
  output logic           unblkValid,
  output logic [IDW-1:0] unblkOwner
);

  localparam logic [ACW-1:0] CACHE_COUNT = ACW'(N);

  assign rspValid = fwdValid && strobe.serve;
  assign rspDest  = fwdMask;
  assign rspType  = strobe.kind;
  assign rspData  = strobe.useWb ? wbData  : lineData;
  assign rspDirty = strobe.useWb ? wbDirty : lineDirty;
  assign rspAcks  = CACHE_COUNT;
  assign stateNew = strobe.newState;

  logic [IDW-1:0] curOwner;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curOwner <= '0;
    end else if (dataInValid) begin
      curOwner <= dataInSender;
    end
  end

  assign unblkValid = unblkReq;
  assign unblkOwner = curOwner;

endmodule

// File: rtl/merged_read_responder.sv
module merged_read_responder
  import mrr_pkg::*;
#(
  parameter int N   = 4,
  parameter int W   = 32,
  localparam int IDW = $clog2(N),
  localparam int ACW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           fwdValid,
  output logic           fwdReady,
  input  logic [N-1:0]   fwdMask,
  input  logic [3:0]     lineState,
  input  logic [W-1:0]   lineData,
  input  logic           lineDirty,
  input  logic [W-1:0]   wbData,
  input  logic           wbDirty,
  output logic           rspValid,
  input  logic           rspReady,
  output logic [N-1:0]   rspDest,
  output logic           rspType,
  output logic [W-1:0]   rspData,
  output logic           rspDirty,
  output logic [ACW-1:0] rspAcks,
  output logic           stateWe,
  output logic [3:0]     stateNew,
  input  logic           dataInValid,
  input  logic [IDW-1:0] dataInSender,
  input  logic           unblkReq,
  output logic           unblkValid,
  output logic [IDW-1:0] unblkOwner
);

  ctrlStrobe_t strobe;

  mrr_ctrl u_ctrl (
    .fwdValid  (fwdValid),
    .lineState (lineState),
    .rspReady  (rspReady),
    .strobe    (strobe),
    .fwdReady  (fwdReady),
    .stateWe   (stateWe)
  );

  mrr_datapath #(.N(N), .W(W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .fwdValid     (fwdValid),
    .fwdMask      (fwdMask),
    .lineData     (lineData),
    .lineDirty    (lineDirty),
    .wbData       (wbData),
    .wbDirty      (wbDirty),
    .rspValid     (rspValid),
    .rspDest      (rspDest),
    .rspType      (rspType),
    .rspData      (rspData),
    .rspDirty     (rspDirty),
    .rspAcks      (rspAcks),
    .stateNew     (stateNew),
    .dataInValid  (dataInValid),
    .dataInSender (dataInSender),
    .unblkReq     (unblkReq),
    .unblkValid   (unblkValid),
    .unblkOwner   (unblkOwner)
  );

endmodule

// File: rtl/mrr_checker.sv
module mrr_checker #(
  parameter int N   = 4,
  parameter int W   = 32,
  localparam int IDW = $clog2(N),
  localparam int ACW = $clog2(N + 1)
) (
  input logic           clk,
  input logic           rstN,
  input logic           fwdValid,
  input logic           fwdReady,
  input logic [3:0]     lineState,
  input logic           rspValid,
  input logic           rspReady,
  input logic           rspType,
  input logic [ACW-1:0] rspAcks,
  input logic           stateWe,
  input logic [3:0]     stateNew,
  input logic           dataInValid,
  input logic [IDW-1:0] dataInSender,
  input logic [IDW-1:0] unblkOwner
);

  logic transient;
  assign transient = (lineState >= 4'd9) && (lineState <= 4'd13);

  assert_transient_stall_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && transient) |-> (!fwdReady && !rspValid && !stateWe));

  assert_ack_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspAcks == ACW'(N)));

  assert_pop_on_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fwdReady || stateWe) |-> (rspValid && rspReady));

  assert_modified_to_owned_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateWe && (lineState == 4'd4 || lineState == 4'd5)) |-> (stateNew == 4'd3));

  assert_evict_plain_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (lineState == 4'd7 || lineState == 4'd8)) |-> (rspType == 1'b0));

  assert_owner_capture_R8: assert property (@(posedge clk) disable iff (!rstN)
    dataInValid |=> (unblkOwner == $past(dataInSender)));

  assert_owner_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !dataInValid |=> $stable(unblkOwner));

endmodule

bind merged_read_responder mrr_checker #(.N(N), .W(W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .fwdValid     (fwdValid),
  .fwdReady     (fwdReady),
  .lineState    (lineState),
  .rspValid     (rspValid),
  .rspReady     (rspReady),
  .rspType      (rspType),
  .rspAcks      (rspAcks),
  .stateWe      (stateWe),
  .stateNew     (stateNew),
  .dataInValid  (dataInValid),
  .dataInSender (dataInSender),
  .unblkOwner   (unblkOwner)
);

// File: tb/sim_merged_read_responder.sv
module sim_merged_read_responder;

  localparam int N   = 4;
  localparam int W   = 32;
  localparam int IDW = $clog2(N);
  localparam int ACW = $clog2(N + 1);

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           fwdValid = 1'b0;
  logic           fwdReady;
  logic [N-1:0]   fwdMask = '0;
  logic [3:0]     lineState = 4'd0;
  logic [W-1:0]   lineData = '0;
  logic           lineDirty = 1'b0;
  logic [W-1:0]   wbData = '0;
  logic           wbDirty = 1'b0;
  logic           rspValid;
  logic           rspReady = 1'b0;
  logic [N-1:0]   rspDest;
  logic           rspType;
  logic [W-1:0]   rspData;
  logic           rspDirty;
  logic [ACW-1:0] rspAcks;
  logic           stateWe;
  logic [3:0]     stateNew;
  logic           dataInValid = 1'b0;
  logic [IDW-1:0] dataInSender = '0;
  logic           unblkReq = 1'b0;
  logic           unblkValid;
  logic [IDW-1:0] unblkOwner;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  merged_read_responder #(.N(N), .W(W)) u0 (.*);

  typedef struct packed {
    logic [3:0]   st;
    logic [N-1:0] mask;
    logic         rdy;
    logic         expValid;
    logic         expType;
    logic         expWb;
    logic         expWe;
    logic [3:0]   expNew;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{4'd3,  4'b0101, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 4'd1},  // R1 owned
    '{4'd4,  4'b0110, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd3, 4'd2},  // R2 dirty-excl
    '{4'd5,  4'b1011, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd3, 4'd2},  // R2 modified
    '{4'd6,  4'b1110, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 4'd3},  // R3 upgrade
    '{4'd7,  4'b0011, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd7, 4'd4},  // R4 evict owned
    '{4'd8,  4'b1100, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd7, 4'd4},  // R4 evict mod
    '{4'd9,  4'b1111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd5},  // R5 transient
    '{4'd13, 4'b0101, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd5},  // R5 transient
    '{4'd5,  4'b0110, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3, 4'd7},  // R7 not ready
    '{4'd10, 4'b1001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd5},  // R5 transient
    '{4'd0,  4'b1001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd5}   // R5 invalid line
  };

  function automatic string reqName(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10 reset state
    check("R10 owner", 64'(unblkOwner), 64'd0);
    check("R10 unblk", 64'(unblkValid), 64'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      fwdValid  = 1'b1;
      fwdMask   = TBL[i].mask;
      lineState = TBL[i].st;
      rspReady  = TBL[i].rdy;
      lineData  = 32'hA5A5_0000 | 32'(i);
      lineDirty = 1'b1;
      wbData    = 32'h5A5A_0000 | 32'(i);
      wbDirty   = 1'b0;
      #1;
      check(reqName(TBL[i].req), 64'(rspValid), 64'(TBL[i].expValid));
      check(reqName(TBL[i].req), 64'(fwdReady), 64'(TBL[i].expValid && TBL[i].rdy));
      check(reqName(TBL[i].req), 64'(stateWe), 64'(TBL[i].expWe));
      if (TBL[i].expWe) check(reqName(TBL[i].req), 64'(stateNew), 64'(TBL[i].expNew));
      if (TBL[i].expValid) begin
        check(reqName(TBL[i].req), 64'(rspDest), 64'(TBL[i].mask));
        check(reqName(TBL[i].req), 64'(rspType), 64'(TBL[i].expType));
        check(reqName(TBL[i].req), 64'(rspData),
              64'(TBL[i].expWb ? (32'h5A5A_0000 | 32'(i)) : (32'hA5A5_0000 | 32'(i))));
        check(reqName(TBL[i].req), 64'(rspDirty), 64'(TBL[i].expWb ? 1'b0 : 1'b1));
        check("R6 acks", 64'(rspAcks), 64'(N));
      end
    end

    // R7: reply held while not ready, then taken
    @(negedge clk);
    lineState = 4'd4; fwdMask = 4'b1010; rspReady = 1'b0;
    #1;
    check("R7 held valid", 64'(rspValid), 64'd1);
    check("R7 no pop", 64'(fwdReady), 64'd0);
    @(negedge clk);
    #1;
    check("R7 still valid", 64'(rspValid), 64'd1);
    check("R7 dest stable", 64'(rspDest), 64'b1010);
    @(negedge clk);
    rspReady = 1'b1;
    #1;
    check("R7 pop", 64'(fwdReady), 64'd1);
    check("R2 write", 64'(stateWe), 64'd1);
    @(negedge clk);
    fwdValid = 1'b0;
    #1;
    check("R7 idle", 64'(rspValid), 64'd0);

    // R8 owner capture
    dataInValid = 1'b1; dataInSender = 2'd2;
    @(negedge clk);
    dataInValid = 1'b0; dataInSender = 2'd3;
    #1;
    check("R8 owner", 64'(unblkOwner), 64'd2);
    // R9 hold and unblock
    @(negedge clk);
    unblkReq = 1'b1;
    #1;
    check("R9 owner hold", 64'(unblkOwner), 64'd2);
    check("R9 unblk valid", 64'(unblkValid), 64'd1);
    @(negedge clk);
    unblkReq = 1'b0; dataInValid = 1'b1; dataInSender = 2'd1;
    #1;
    check("R9 no early change", 64'(unblkOwner), 64'd2);
    @(negedge clk);
    dataInValid = 1'b0;
    #1;
    check("R8 owner update", 64'(unblkOwner), 64'd1);
    check("R9 unblk idle", 64'(unblkValid), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule